// File: doc/BRIEF.md
# Buffered Many-to-Few Cell Concentrator

This block sits in front of a single switch module. It takes in fixed-size cells from a wide set of input lines and forwards them onto a narrow set of output lanes that feed the module. One clock cycle is one cell slot. A cell is taken only when its header carries the identity of the attached module. All other cells are thrown away without touching the buffer.

In each slot at most one cell leaves on each output lane. Cells that cannot leave in their arrival slot go into a shared buffer, which all input lines use in common. Buffered cells are sent in later slots, the oldest first. If the buffer runs out of room, the surplus cells are dropped and a saturating counter records how many were lost. The output lanes use the same valid/data format as the input lines, so two instances can be chained. The first stage's outputs then drive the second stage's inputs. The full build is 64 inputs and 8 outputs. The defaults are scaled down so the design can be checked exhaustively.

Top module: `cell_concentrator`

## Requirements
- R1: While reset is held and on the first cycle after it, every bit of `outValid` is 0 and `overflowCount` is 0.
- R2: A cell is accepted only when its `inValid` bit is 1 and header bits [ID_LSB+ID_W-1:ID_LSB] (bits [15:12] by default) equal `moduleId`. Any other cell never reaches an output, occupies no buffer entry and never increments `overflowCount`.
- R3: Outputs are registered. A cell that leaves in slot t shows up on the outputs after the clock edge that ends slot t. Valid lanes are always packed from lane 0 upward with no gaps, and at most NUM_OUT cells leave per slot.
- R4: Output lanes are filled in a fixed order. Buffered cells come first, oldest first. New accepted cells of the same slot follow, in ascending input index.
- R5: Accepted cells that find no free lane are stored in the shared buffer and released in later slots. If the buffer held at least NUM_OUT cells at the start of a slot, all NUM_OUT lanes are valid for that slot.
- R6: Cells accepted from any one input line leave in the order in which they arrived.
- R7: If the buffer fills, the surplus cells with the highest input indices are dropped. `overflowCount` rises by the number dropped in that slot and saturates at 2^CNT_W-1. It never decreases, and it changes only in slots that leave the buffer full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle per cell slot |
| rstN | input | 1 | Asynchronous active-low reset |
| moduleId | input | ID_W | Identity of the attached switch module |
| inValid | input | NUM_IN | Per-line cell-present flag |
| inCell | input | NUM_IN x CELL_W | Per-line cell, header field included |
| outValid | output | NUM_OUT | Per-lane cell-present flag |
| outCell | output | NUM_OUT x CELL_W | Per-lane cell |
| overflowCount | output | CNT_W | Saturating count of dropped cells |

## Verification
The bench sweeps every module identity against header patterns in which only a few lines match. A filter that compared the wrong bits, or that let cells it rejected take buffer space, would show extra cells or too early a drop. Full-width bursts followed by light slots check that backlog goes ahead of new arrivals and that cells leave in ascending line order. A design that swapped these priorities, or that let a buffered cell be overtaken, would put cells on the wrong lane or leave a gap in a line's sequence. A long run with every line matching fills the buffer and pushes the drop counter up to its limit. An off-by-one in the room calculation, or a counter that wrapped, would then miscompare.

// File: rtl/conc_pkg.sv
package conc_pkg;
  // Width of each strobe field; wide enough for any practical buffer depth.
  localparam int CTL_W = 16;

  // Per-slot directions from control to datapath.
  typedef struct packed {
    logic [CTL_W-1:0] head;      // read pointer of oldest buffered cell
    logic [CTL_W-1:0] fill;      // cells held at slot start
    logic [CTL_W-1:0] popNum;    // buffered cells leaving this slot
    logic [CTL_W-1:0] storeNum;  // new surplus cells written this slot
  } slotCtl_t;
endpackage

// File: rtl/conc_ctrl.sv
module conc_ctrl
  import conc_pkg::*;
#(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 2,
  parameter int BUF_AW  = 3,
  parameter int CNT_W   = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [$clog2(NUM_IN+1)-1:0]  acceptCount,
  output slotCtl_t                     slotCtl,
  output logic [CNT_W-1:0]             overflowCount
);
  localparam int DEPTH = 1 << BUF_AW;

  logic [BUF_AW-1:0] headQ;
  logic [BUF_AW:0]   fillQ;
  logic [CNT_W:0]    ovfSum;
  int popN, freeN, spillN, roomN, storeN, dropN;

  always_comb begin
    popN   = (int'(fillQ) > NUM_OUT) ? NUM_OUT : int'(fillQ);
    freeN  = NUM_OUT - popN;
    spillN = (int'(acceptCount) > freeN) ? int'(acceptCount) - freeN : 0;
    roomN  = DEPTH - int'(fillQ) + popN;
    storeN = (spillN < roomN) ? spillN : roomN;
    dropN  = spillN - storeN;
    ovfSum = {1'b0, overflowCount} + (CNT_W+1)'(dropN);
    slotCtl.head     = CTL_W'(headQ);
    slotCtl.fill     = CTL_W'(fillQ);
    slotCtl.popNum   = CTL_W'(popN);
    slotCtl.storeNum = CTL_W'(storeN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ         <= '0;
      fillQ         <= '0;
      overflowCount <= '0;
    end else begin
      headQ         <= headQ + BUF_AW'(popN);
      fillQ         <= fillQ + (BUF_AW+1)'(storeN) - (BUF_AW+1)'(popN);
      overflowCount <= ovfSum[CNT_W] ? '1 : ovfSum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/conc_datapath.sv
module conc_datapath
  import conc_pkg::*;
#(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 2,
  parameter int CELL_W  = 16,
  parameter int ID_W    = 4,
  parameter int ID_LSB  = 12,
  parameter int BUF_AW  = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [ID_W-1:0]                   moduleId,
  input  logic [NUM_IN-1:0]                 inValid,
  input  logic [NUM_IN-1:0][CELL_W-1:0]     inCell,
  input  slotCtl_t                          slotCtl,
  output logic [$clog2(NUM_IN+1)-1:0]       acceptCount,
  output logic [NUM_OUT-1:0]                outValid,
  output logic [NUM_OUT-1:0][CELL_W-1:0]    outCell
);
  localparam int DEPTH = 1 << BUF_AW;
  localparam int ACC_W = $clog2(NUM_IN+1);

  logic [CELL_W-1:0]              bufMem [DEPTH];
  logic [NUM_IN-1:0]              hit;
  int                             rank [NUM_IN];
  logic [NUM_OUT-1:0]             nxtValid;
  logic [NUM_OUT-1:0][CELL_W-1:0] nxtCell;
  int headN, fillN, popN, freeN, storeN;

  // Header match per input line
  for (genvar i = 0; i < NUM_IN; i++) begin : g_match
    assign hit[i] = inValid[i] && (inCell[i][ID_LSB +: ID_W] == moduleId);
  end

  // Position of each accepted cell among this slot's arrivals
  always_comb begin
    int running;
    running = 0;
    for (int i = 0; i < NUM_IN; i++) begin
      rank[i] = running;
      running = running + int'(hit[i]);
    end
    acceptCount = ACC_W'(running);
  end

  always_comb begin
    headN  = int'(slotCtl.head);
    fillN  = int'(slotCtl.fill);
    popN   = int'(slotCtl.popNum);
    storeN = int'(slotCtl.storeNum);
    freeN  = NUM_OUT - popN;
  end

  // Lane selection: backlog first, then new arrivals by rank
  always_comb begin
    for (int j = 0; j < NUM_OUT; j++) begin
      nxtValid[j] = 1'b0;
      nxtCell[j]  = '0;
      if (j < popN) begin
        nxtValid[j] = 1'b1;
        nxtCell[j]  = bufMem[BUF_AW'(headN + j)];
      end else begin
        for (int i = 0; i < NUM_IN; i++) begin
          if (hit[i] && rank[i] == j - popN) begin
            nxtValid[j] = 1'b1;
            nxtCell[j]  = inCell[i];
          end
        end
      end
    end
  end

  // Surplus arrivals appended behind the current backlog
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_IN; i++) begin
      if (hit[i] && rank[i] >= freeN && rank[i] - freeN < storeN)
        bufMem[BUF_AW'(headN + fillN + rank[i] - freeN)] <= inCell[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= '0;
      outCell  <= '0;
    end else begin
      outValid <= nxtValid;
      outCell  <= nxtCell;
    end
  end
endmodule

// File: rtl/cell_concentrator.sv
module cell_concentrator
  import conc_pkg::*;
#(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 2,
  parameter int CELL_W  = 16,
  parameter int ID_W    = 4,
  parameter int ID_LSB  = 12,
  parameter int BUF_AW  = 3,
  parameter int CNT_W   = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ID_W-1:0]                moduleId,
  input  logic [NUM_IN-1:0]              inValid,
  input  logic [NUM_IN-1:0][CELL_W-1:0]  inCell,
  output logic [NUM_OUT-1:0]             outValid,
  output logic [NUM_OUT-1:0][CELL_W-1:0] outCell,
  output logic [CNT_W-1:0]               overflowCount
);
  localparam int ACC_W = $clog2(NUM_IN+1);

  slotCtl_t          slotCtl;
  logic [ACC_W-1:0]  acceptCount;

  conc_ctrl #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .BUF_AW(BUF_AW), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .acceptCount(acceptCount),
    .slotCtl(slotCtl), .overflowCount(overflowCount)
  );

  conc_datapath #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .CELL_W(CELL_W),
    .ID_W(ID_W), .ID_LSB(ID_LSB), .BUF_AW(BUF_AW)
  ) uPath (
    .clk(clk), .rstN(rstN), .moduleId(moduleId), .inValid(inValid),
    .inCell(inCell), .slotCtl(slotCtl), .acceptCount(acceptCount),
    .outValid(outValid), .outCell(outCell)
  );
endmodule

// File: rtl/cell_concentrator_chk.sv
module cell_concentrator_chk
  import conc_pkg::*;
#(
  parameter int NUM_OUT = 2,
  parameter int BUF_AW  = 3,
  parameter int CNT_W   = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_OUT-1:0] outValid,
  input logic [CNT_W-1:0]   overflowCount,
  input slotCtl_t           slotCtl
);
  localparam int DEPTH = 1 << BUF_AW;

  // R3
  lanes_packed_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((outValid + 1'b1) & outValid) == '0);

  // R5
  backlog_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(slotCtl.fill) >= NUM_OUT |=> &outValid);

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(slotCtl.fill) <= DEPTH);

  // R7
  ovf_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> overflowCount >= $past(overflowCount));

  // R7
  ovf_only_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(overflowCount) |-> int'(slotCtl.fill) == DEPTH);
endmodule

bind cell_concentrator cell_concentrator_chk #(
  .NUM_OUT(NUM_OUT), .BUF_AW(BUF_AW), .CNT_W(CNT_W)
) uChk (
  .clk(clk), .rstN(rstN), .outValid(outValid),
  .overflowCount(overflowCount), .slotCtl(slotCtl)
);

// File: tb/tb_cell_concentrator.sv
module tb_cell_concentrator;
  localparam int NI  = 8;
  localparam int NO  = 2;
  localparam int CW  = 16;
  localparam int IW  = 4;
  localparam int IL  = 12;
  localparam int AW  = 3;
  localparam int DEP = 1 << AW;
  localparam int OW  = 8;
  localparam int OMAX = (1 << OW) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                   rstN;
  logic [IW-1:0]          moduleId;
  logic [NI-1:0]          inValid;
  logic [NI-1:0][CW-1:0]  inCell;
  logic [NO-1:0]          outValid;
  logic [NO-1:0][CW-1:0]  outCell;
  logic [OW-1:0]          overflowCount;

  cell_concentrator dut (
    .clk(clk), .rstN(rstN), .moduleId(moduleId), .inValid(inValid),
    .inCell(inCell), .outValid(outValid), .outCell(outCell),
    .overflowCount(overflowCount)
  );

  int vecs = 0;
  int errs = 0;
  int seq  = 0;
  logic [CW-1:0] q[$];
  logic          expValid [NO];
  logic [CW-1:0] expCell  [NO];
  int            expOvf = 0;

  function automatic logic [CW-1:0] mk(input int id, input int line, input int s);
    return {4'(id), 8'(s), 4'(line)};
  endfunction

  // One cell slot: drive, predict, sample after the edge
  task automatic slot(input logic [NI-1:0] v, input logic [NI-1:0][CW-1:0] c,
                      input string tag);
    int n;
    @(negedge clk);
    inValid = v;
    inCell  = c;
    n = 0;
    for (int j = 0; j < NO; j++) begin expValid[j] = 1'b0; expCell[j] = '0; end
    while (n < NO && q.size() > 0) begin
      expCell[n] = q.pop_front(); expValid[n] = 1'b1; n++;
    end
    for (int i = 0; i < NI; i++) begin
      if (v[i] && c[i][IL +: IW] == moduleId) begin
        if (n < NO) begin expCell[n] = c[i]; expValid[n] = 1'b1; n++; end
        else if (q.size() < DEP) q.push_back(c[i]);
        else if (expOvf < OMAX) expOvf++;
      end
    end
    @(posedge clk);
    #1;
    for (int j = 0; j < NO; j++) begin
      vecs++;
      if (outValid[j] !== expValid[j] || (expValid[j] && outCell[j] !== expCell[j])) begin
        errs++;
        $display("FAIL %s lane %0d: actual v=%b c=%h expected v=%b c=%h",
                 tag, j, outValid[j], outCell[j], expValid[j], expCell[j]);
      end
    end
    vecs++;
    if (int'(overflowCount) != expOvf) begin
      errs++;
      $display("FAIL %s overflow: actual %0d expected %0d", tag, overflowCount, expOvf);
    end
  endtask

  task automatic idle(input int k, input string tag);
    for (int s = 0; s < k; s++) slot('0, '0, tag);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    logic [NI-1:0][CW-1:0] c;
    logic [NI-1:0]         v;
    rstN = 1'b0; moduleId = '0; inValid = '0; inCell = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state while held
    vecs++;
    if (outValid !== '0 || overflowCount !== '0) begin
      errs++;
      $display("FAIL R1 in reset: actual v=%b ovf=%0d expected v=0 ovf=0", outValid, overflowCount);
    end
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    vecs++;
    if (outValid !== '0 || overflowCount !== '0) begin
      errs++;
      $display("FAIL R1 after reset: actual v=%b ovf=%0d expected v=0 ovf=0", outValid, overflowCount);
    end

    // R2: header filter sweep over every module identity
    for (int m = 0; m < 16; m++) begin
      moduleId = IW'(m);
      for (int k = 0; k < 4; k++) begin
        for (int i = 0; i < NI; i++) c[i] = mk((i*3 + k) % 16, i, seq++);
        slot('1, c, "R2");
        for (int i = 0; i < NI; i++) c[i] = mk(m, i, seq++);
        slot(8'(16'h5A >> k), c, "R2");
      end
      idle(5, "R2");
    end

    // R4/R5: full burst then light traffic behind the backlog
    moduleId = 4'd6;
    for (int i = 0; i < NI; i++) c[i] = mk(6, i, seq++);
    slot('1, c, "R5");
    for (int i = 0; i < NI; i++) c[i] = mk(6, i, seq++);
    slot(8'b0010_0010, c, "R4");
    slot(8'b1000_0001, c, "R4");
    idle(6, "R5");

    // R3/R6: pseudo-random traffic mixing matching and foreign cells
    for (int s = 0; s < 400; s++) begin
      for (int i = 0; i < NI; i++) c[i] = mk(($urandom % 3 == 0) ? 9 : 6, i, seq++);
      v = 8'($urandom) & 8'($urandom);
      slot(v, c, (s % 2 == 0) ? "R6" : "R3");
    end
    idle(6, "R6");

    // R2: foreign cells arriving while the buffer is full take no room
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < NI; i++) c[i] = mk(6, i, seq++);
      slot('1, c, "R5");
    end
    for (int i = 0; i < NI; i++) c[i] = mk(3, i, seq++);
    slot('1, c, "R2");
    idle(6, "R2");

    // R7: sustained overload fills the buffer and saturates the counter
    for (int s = 0; s < 60; s++) begin
      for (int i = 0; i < NI; i++) c[i] = mk(6, i, seq++);
      slot('1, c, "R7");
    end
    idle(6, "R7");

    summary();
    $finish;
  end

  initial begin
    #(4 * 150000);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule